// File: doc/BRIEF.md
# Packet Timestamp Capture Unit

This block records the value of a free-running 64-bit precision time counter at the instant an Ethernet frame begins, on both the receive and the transmit side. A capture happens only while the time counter is running. On receive, the stamp is held in a register. It can also be carried in-band: the 8 stamp bytes are placed in front of the frame as alignment padding, in the byte stream that goes on to the buffer writer.

On transmit, software marks a frame for stamping in one of two ways: a per-frame request that arrives with the start-of-frame strobe, or a global mode that stamps every frame. Each stamp is stored together with the packet identifier supplied for that frame, in one of two slots. Software can then match a stamp to its frame by identifier. A slot stays valid until software reads its upper word. A masked event pulse reports each slot write, and a second pulse reports an overwrite of unread data.

The receive byte stream passes through a fixed-latency path. That path leaves room to emit the stamp ahead of the first frame byte without stalling the source.

Top module: `pkt_stamp_unit`

## Requirements
- R1: While `tmr_en` is 0, start-of-frame strobes on either side have no effect: `rx_ts`, the transmit slots and the event pulses keep their values, and no bytes are inserted.
- R2: When a receive byte with `rx_in_valid`=1 and `rx_in_sof`=1 arrives while `rx_stamp_en`=1, `rx_ts` shows the `time_in` value of that cycle from the next cycle on. Otherwise `rx_ts` holds its value.
- R3: With insertion active, the output stream carries 8 stamp bytes, most significant byte first, on consecutive cycles, with `rx_out_valid`=1. The first of these bytes appears 2 cycles after the start-of-frame byte was presented and carries `rx_out_sof`. The frame bytes follow directly, without a start-of-frame mark.
- R4: Insertion is active only if `rx_inband_en`=1, `rx_stamp_en`=1 and `rx_pad_len` >= 8. Otherwise the frame leaves unmodified, 10 cycles after entry, with `rx_out_sof` on its first byte.
- R5: A `tx_sof` pulse with `tx_req`=1 or `tx_all_en`=1 stores the `time_in` value of that cycle together with `tx_id` into a slot. The slot is visible on the next cycle. Slot k occupies bits [64k+63:64k] of `tx_slot_ts` and bits [16k+15:16k] of `tx_slot_id`.
- R6: The slot written is the one after the last written slot, if that slot is free. Otherwise the other slot is used if it is free. The written slot's bit in `tx_slot_vld` becomes 1.
- R7: A pulse on `tx_rd_hi[k]` clears `tx_slot_vld[k]` on the next cycle. If a write to slot k occurs in the same cycle, the write wins.
- R8: `tx_evt` pulses for exactly one cycle after each slot write if `tx_evt_en`=1, and stays 0 if `tx_evt_en`=0.
- R9: A write while both slots are valid overwrites the older slot and pulses `tx_ovf` for one cycle. Without such a write, `tx_ovf` stays 0.
- R10: After reset, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tmr_en | input | 1 | Time counter running; gates all captures |
| time_in | input | 64 | Current precision time value |
| rx_stamp_en | input | 1 | Enable receive stamping |
| rx_inband_en | input | 1 | Enable in-band stamp insertion |
| rx_pad_len | input | 5 | Configured receive alignment pad length in bytes |
| rx_in_valid | input | 1 | Receive byte valid |
| rx_in_sof | input | 1 | Receive byte is first of frame |
| rx_in_data | input | 8 | Receive byte |
| rx_out_valid | output | 1 | Output byte valid |
| rx_out_sof | output | 1 | Output byte is first of frame (first stamp byte if inserted) |
| rx_out_data | output | 8 | Output byte |
| rx_ts | output | 64 | Last receive stamp |
| tx_sof | input | 1 | Transmission of a frame starts |
| tx_req | input | 1 | Per-frame stamp request, sampled with `tx_sof` |
| tx_id | input | 16 | Packet identifier, sampled with `tx_sof` |
| tx_all_en | input | 1 | Stamp every transmitted frame |
| tx_evt_en | input | 1 | Enable for the slot-write event |
| tx_rd_hi | input | 2 | Upper-word read strobe per slot |
| tx_slot_ts | output | 128 | Slot stamps, slot 1 in the upper half |
| tx_slot_id | output | 32 | Slot identifiers, slot 1 in the upper half |
| tx_slot_vld | output | 2 | Slot valid bits |
| tx_evt | output | 1 | Slot-write event pulse |
| tx_ovf | output | 1 | Overwrite-of-unread-slot pulse |

## Verification
The bench builds the block with its defaults: a 64-bit time value, 16-bit identifiers and an 8-stage stamp burst. With these values, every configured pad length from 0 to 15 and all eight combinations of the timer, stamp and in-band enables can be swept, so the pad-length threshold is crossed at its exact boundary. A scripted series of transmit stamps, interleaved with slot reads, drives the slot choice through every combination of valid bits, including same-cycle read and write. Expected stamps come from an arithmetic function of the cycle count that the bench itself drives into `time_in`.

// File: rtl/pkt_stamp_pkg.sv
// Shared constants and types of the packet timestamp capture unit.
// Assumes byte-wide receive streams.
package pkt_stamp_pkg;
    localparam int BYTE_W = 8;
    localparam int N_SLOTS = 2;

    // One beat of the receive byte stream as it moves through the delay line.
    typedef struct packed {
        logic                valid;
        logic                sof;
        logic [BYTE_W-1:0]   data;
    } rx_beat_t;
endpackage

// File: rtl/pkt_rx_capture.sv
// Receive-side capture: latches the time value on a start-of-frame byte
// and decides whether the stamp is inserted in-band.
// Assumes rx_in_sof is only meaningful together with rx_in_valid.
module pkt_rx_capture #(
    parameter int TS_W  = 64,
    parameter int PAD_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tmr_en,
    input  logic [TS_W-1:0]  time_in,
    input  logic             stamp_en,
    input  logic             inband_en,
    input  logic [PAD_W-1:0] pad_len,
    input  logic             in_valid,
    input  logic             in_sof,
    output logic [TS_W-1:0]  rx_ts,
    output logic             start_ins
);
    localparam int NB = TS_W / pkt_stamp_pkg::BYTE_W;
    localparam logic [PAD_W-1:0] MIN_PAD = PAD_W'(NB);

    logic hit;

    // Qualify a frame start for stamping.
    always_comb hit = in_valid && in_sof && tmr_en && stamp_en;

    // Request insertion only when the pad can hold the whole stamp.
    always_comb start_ins = hit && inband_en && (pad_len >= MIN_PAD);

    // Hold the most recent receive stamp.
    always_ff @(posedge clk) begin
        if (!rst_n)   rx_ts <= '0;
        else if (hit) rx_ts <= time_in;
    end

    p_hold_when_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> $stable(rx_ts));
    p_hold_without_sof_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(in_valid && in_sof) |=> $stable(rx_ts));
endmodule

// File: rtl/pkt_rx_inserter.sv
// Receive stream path: a fixed delay line carries frame bytes, and a
// shift register emits the stamp bytes, most significant first, ahead of them.
// Assumes frames are separated by at least NB idle cycles.
module pkt_rx_inserter #(
    parameter int TS_W = 64
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              in_valid,
    input  logic                              in_sof,
    input  logic [pkt_stamp_pkg::BYTE_W-1:0]  in_data,
    input  logic                              start_ins,
    input  logic [TS_W-1:0]                   stamp,
    output logic                              out_valid,
    output logic                              out_sof,
    output logic [pkt_stamp_pkg::BYTE_W-1:0]  out_data
);
    import pkt_stamp_pkg::*;
    localparam int NB    = TS_W / BYTE_W;
    localparam int DEPTH = NB + 1;
    localparam int CW    = $clog2(NB + 1);

    rx_beat_t          dly [DEPTH];
    logic [TS_W-1:0]   sr;
    logic [CW-1:0]     cnt;

    // Shift frame bytes through the delay line; drop sof when a stamp leads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) dly[i] <= '0;
        end else begin
            dly[0] <= '{valid: in_valid, sof: in_sof && !start_ins, data: in_data};
            for (int i = 1; i < DEPTH; i++) dly[i] <= dly[i-1];
        end
    end

    // Load the stamp and count the inserted bytes out.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sr  <= '0;
            cnt <= '0;
        end else if (start_ins) begin
            sr  <= stamp;
            cnt <= CW'(NB);
        end else if (cnt != '0) begin
            sr  <= sr << BYTE_W;
            cnt <= cnt - 1'b1;
        end
    end

    // Select a stamp byte while a burst runs, else the delayed frame byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_sof   <= 1'b0;
            out_data  <= '0;
        end else if (cnt != '0) begin
            out_valid <= 1'b1;
            out_sof   <= (cnt == CW'(NB));
            out_data  <= sr[TS_W-1 -: BYTE_W];
        end else begin
            out_valid <= dly[DEPTH-1].valid;
            out_sof   <= dly[DEPTH-1].sof;
            out_data  <= dly[DEPTH-1].data;
        end
    end

    p_burst_valid_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt != '0) |=> out_valid);
    p_burst_sof_first_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == CW'(NB)) |=> (out_valid && out_sof));
endmodule

// File: rtl/pkt_tx_slots.sv
// Transmit stamp store: two slots of {stamp, packet ID} filled in turn,
// preferring a free slot, overwriting the older one when both are unread.
// Assumes tx_sof is a single-cycle pulse per frame.
module pkt_tx_slots #(
    parameter int TS_W = 64,
    parameter int ID_W = 16
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                tmr_en,
    input  logic [TS_W-1:0]                     time_in,
    input  logic                                sof,
    input  logic                                req,
    input  logic                                all_en,
    input  logic [ID_W-1:0]                     id_in,
    input  logic                                evt_en,
    input  logic [pkt_stamp_pkg::N_SLOTS-1:0]   rd_hi,
    output logic [pkt_stamp_pkg::N_SLOTS*TS_W-1:0] slot_ts,
    output logic [pkt_stamp_pkg::N_SLOTS*ID_W-1:0] slot_id,
    output logic [pkt_stamp_pkg::N_SLOTS-1:0]   slot_vld,
    output logic                                evt,
    output logic                                ovf
);
    import pkt_stamp_pkg::*;

    logic [TS_W-1:0]    ts_q [N_SLOTS];
    logic [ID_W-1:0]    id_q [N_SLOTS];
    logic [N_SLOTS-1:0] vld;
    logic               ptr;
    logic               wr;
    logic               tgt;

    // Decide whether this frame start is stamped.
    always_comb wr = tmr_en && sof && (req || all_en);

    // Pick the slot: next in turn if free, else the other if free, else oldest.
    always_comb begin
        if (!vld[ptr])       tgt = ptr;
        else if (!vld[!ptr]) tgt = !ptr;
        else                 tgt = ptr;
    end

    // Update slots, valid bits, turn pointer and event pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_SLOTS; i++) begin
                ts_q[i] <= '0;
                id_q[i] <= '0;
            end
            vld <= '0;
            ptr <= 1'b0;
            evt <= 1'b0;
            ovf <= 1'b0;
        end else begin
            evt <= 1'b0;
            ovf <= 1'b0;
            for (int i = 0; i < N_SLOTS; i++)
                if (rd_hi[i]) vld[i] <= 1'b0;
            if (wr) begin
                ts_q[tgt] <= time_in;
                id_q[tgt] <= id_in;
                vld[tgt]  <= 1'b1;
                ptr       <= !tgt;
                evt       <= evt_en;
                ovf       <= &vld;
            end
        end
    end

    // Pack slots onto the flat output buses.
    for (genvar g = 0; g < N_SLOTS; g++) begin : g_pack
        assign slot_ts[g*TS_W +: TS_W] = ts_q[g];
        assign slot_id[g*ID_W +: ID_W] = id_q[g];
        p_read_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_hi[g] && !wr) |=> !slot_vld[g]);
    end
    assign slot_vld = vld;

    p_ovf_only_when_full_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |-> ($past(vld) == 2'b11));
    p_evt_after_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        evt |-> (vld != '0));
    p_no_write_stopped_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en |=> (!evt && !ovf));
endmodule

// File: rtl/pkt_stamp_unit.sv
// Top of the packet timestamp capture unit: receive capture with optional
// in-band insertion, and a two-slot transmit stamp store.
// Assumes one synchronous clock domain for time value, streams and control.
module pkt_stamp_unit #(
    parameter int TS_W  = 64,
    parameter int ID_W  = 16,
    parameter int PAD_W = 5
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 tmr_en,
    input  logic [TS_W-1:0]      time_in,
    input  logic                 rx_stamp_en,
    input  logic                 rx_inband_en,
    input  logic [PAD_W-1:0]     rx_pad_len,
    input  logic                 rx_in_valid,
    input  logic                 rx_in_sof,
    input  logic [7:0]           rx_in_data,
    output logic                 rx_out_valid,
    output logic                 rx_out_sof,
    output logic [7:0]           rx_out_data,
    output logic [TS_W-1:0]      rx_ts,
    input  logic                 tx_sof,
    input  logic                 tx_req,
    input  logic [ID_W-1:0]      tx_id,
    input  logic                 tx_all_en,
    input  logic                 tx_evt_en,
    input  logic [1:0]           tx_rd_hi,
    output logic [2*TS_W-1:0]    tx_slot_ts,
    output logic [2*ID_W-1:0]    tx_slot_id,
    output logic [1:0]           tx_slot_vld,
    output logic                 tx_evt,
    output logic                 tx_ovf
);
    localparam int NB = TS_W / pkt_stamp_pkg::BYTE_W;
    localparam logic [PAD_W-1:0] MIN_PAD = PAD_W'(NB);

    logic start_ins;

    pkt_rx_capture #(.TS_W(TS_W), .PAD_W(PAD_W)) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .tmr_en    (tmr_en),
        .time_in   (time_in),
        .stamp_en  (rx_stamp_en),
        .inband_en (rx_inband_en),
        .pad_len   (rx_pad_len),
        .in_valid  (rx_in_valid),
        .in_sof    (rx_in_sof),
        .rx_ts     (rx_ts),
        .start_ins (start_ins)
    );

    pkt_rx_inserter #(.TS_W(TS_W)) u_ins (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rx_in_valid),
        .in_sof    (rx_in_sof),
        .in_data   (rx_in_data),
        .start_ins (start_ins),
        .stamp     (time_in),
        .out_valid (rx_out_valid),
        .out_sof   (rx_out_sof),
        .out_data  (rx_out_data)
    );

    pkt_tx_slots #(.TS_W(TS_W), .ID_W(ID_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .tmr_en   (tmr_en),
        .time_in  (time_in),
        .sof      (tx_sof),
        .req      (tx_req),
        .all_en   (tx_all_en),
        .id_in    (tx_id),
        .evt_en   (tx_evt_en),
        .rd_hi    (tx_rd_hi),
        .slot_ts  (tx_slot_ts),
        .slot_id  (tx_slot_id),
        .slot_vld (tx_slot_vld),
        .evt      (tx_evt),
        .ovf      (tx_ovf)
    );

    p_insert_needs_pad_r4: assert property (@(posedge clk) disable iff (!rst_n)
        start_ins |-> (rx_pad_len >= MIN_PAD && rx_inband_en && tmr_en));
endmodule

// File: tb/tb_pkt_stamp_unit.sv
module tb_pkt_stamp_unit;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #4 clk = ~clk;   // 125 MHz

    logic [31:0] cyc = '0;
    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [63:0] tval(input logic [31:0] c);
        return {32'hC0DE_0000 + c, c * 32'h9E37_79B9};
    endfunction

    logic tmr_en = 0, rx_stamp_en = 0, rx_inband_en = 0;
    logic [4:0] rx_pad_len = '0;
    logic rx_in_valid = 0, rx_in_sof = 0;
    logic [7:0] rx_in_data = '0;
    logic rx_out_valid, rx_out_sof;
    logic [7:0] rx_out_data;
    logic [63:0] rx_ts;
    logic tx_sof = 0, tx_req = 0, tx_all_en = 0, tx_evt_en = 0;
    logic [15:0] tx_id = '0;
    logic [1:0] tx_rd_hi = '0;
    logic [127:0] tx_slot_ts;
    logic [31:0] tx_slot_id;
    logic [1:0] tx_slot_vld;
    logic tx_evt, tx_ovf;
    logic [63:0] time_in;
    assign time_in = tval(cyc);

    pkt_stamp_unit dut (
        .clk(clk), .rst_n(rst_n), .tmr_en(tmr_en), .time_in(time_in),
        .rx_stamp_en(rx_stamp_en), .rx_inband_en(rx_inband_en), .rx_pad_len(rx_pad_len),
        .rx_in_valid(rx_in_valid), .rx_in_sof(rx_in_sof), .rx_in_data(rx_in_data),
        .rx_out_valid(rx_out_valid), .rx_out_sof(rx_out_sof), .rx_out_data(rx_out_data),
        .rx_ts(rx_ts), .tx_sof(tx_sof), .tx_req(tx_req), .tx_id(tx_id),
        .tx_all_en(tx_all_en), .tx_evt_en(tx_evt_en), .tx_rd_hi(tx_rd_hi),
        .tx_slot_ts(tx_slot_ts), .tx_slot_id(tx_slot_id), .tx_slot_vld(tx_slot_vld),
        .tx_evt(tx_evt), .tx_ovf(tx_ovf)
    );

    int n_run = 0, n_fail = 0;
    bit done = 0;

    task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk); #1;
    endtask

    // Output stream capture, sampled away from the active edge.
    logic [7:0] cap_d [64];
    logic       cap_s [64];
    int         cap_n = 0;
    logic [31:0] first_cyc = '0;
    always @(negedge clk) begin
        if (rst_n && rx_out_valid && cap_n < 64) begin
            if (cap_n == 0) first_cyc = cyc;
            cap_d[cap_n] = rx_out_data;
            cap_s[cap_n] = rx_out_sof;
            cap_n++;
        end
    end

    // Send one frame and compare the stream and rx_ts (R1..R4).
    task automatic rx_frame(input int len, input bit t_en, input bit s_en, input bit i_en, input logic [4:0] pad);
        logic [63:0] prev_ts, stamp, exp_ts;
        logic [31:0] t0;
        bit ins, upd;
        int bad, exp_n;
        tmr_en = t_en; rx_stamp_en = s_en; rx_inband_en = i_en; rx_pad_len = pad;
        step();
        prev_ts = rx_ts;
        cap_n = 0;
        t0 = cyc;
        stamp = tval(t0);
        upd = t_en && s_en;
        ins = upd && i_en && (pad >= 5'd8);
        for (int b = 0; b < len; b++) begin
            rx_in_valid = 1; rx_in_sof = (b == 0); rx_in_data = 8'(b * 17 + len);
            step();
        end
        rx_in_valid = 0; rx_in_sof = 0; rx_in_data = '0;
        repeat (20) step();
        @(negedge clk);
        exp_ts = upd ? stamp : prev_ts;
        chk(rx_ts == exp_ts, upd ? "R2 rx_ts captured" : "R1/R2 rx_ts held", rx_ts, exp_ts);
        exp_n = len + (ins ? 8 : 0);
        chk(cap_n == exp_n, ins ? "R3 inserted length" : "R4 passthrough length", cap_n, exp_n);
        chk(first_cyc == t0 + (ins ? 2 : 10), ins ? "R3 latency" : "R4 latency", first_cyc, t0 + (ins ? 2 : 10));
        bad = 0;
        for (int i = 0; i < exp_n && i < cap_n; i++) begin
            logic [7:0] e;
            if (ins && i < 8) e = stamp[63 - 8*i -: 8];
            else e = 8'((i - (ins ? 8 : 0)) * 17 + len);
            if (cap_d[i] !== e || cap_s[i] !== (i == 0)) bad++;
        end
        chk(bad == 0, ins ? "R3 stamp bytes and sof" : "R4 unmodified bytes and sof", bad, 0);
    endtask

    // Bench model of the transmit slots.
    logic [1:0]  m_vld = '0;
    logic        m_ptr = 0;
    logic [63:0] m_ts [2];
    logic [15:0] m_id [2];

    task automatic tx_check(input bit e_evt, input bit e_ovf, input string tag);
        chk(tx_slot_vld == m_vld, {tag, " R6 valid bits"}, tx_slot_vld, m_vld);
        chk(tx_slot_ts == {m_ts[1], m_ts[0]} && tx_slot_id == {m_id[1], m_id[0]},
            {tag, " R5 slot contents"}, {tx_slot_id, tx_slot_ts[63:0]}, {m_id[1], m_id[0], m_ts[0]});
        chk(tx_evt == e_evt, {tag, " R8 event"}, tx_evt, e_evt);
        chk(tx_ovf == e_ovf, {tag, " R9 overflow"}, tx_ovf, e_ovf);
    endtask

    task automatic tx_frame(input bit t_en, input bit req, input bit all, input bit ev, input logic [15:0] id, input logic [1:0] rd);
        bit w, e_ovf;
        logic tgt;
        logic [31:0] t0;
        tmr_en = t_en; tx_req = req; tx_all_en = all; tx_evt_en = ev; tx_id = id;
        tx_sof = 1; tx_rd_hi = rd;
        t0 = cyc;
        w = t_en && (req || all);
        e_ovf = 0;
        if (w) begin
            tgt = !m_vld[m_ptr] ? m_ptr : (!m_vld[!m_ptr] ? !m_ptr : m_ptr);
            e_ovf = (m_vld == 2'b11);
        end
        m_vld = m_vld & ~rd;
        if (w) begin
            m_vld[tgt] = 1; m_ts[tgt] = tval(t0); m_id[tgt] = id; m_ptr = !tgt;
        end
        step();
        tx_sof = 0; tx_req = 0; tx_rd_hi = '0;
        @(negedge clk);
        tx_check(w && ev, e_ovf, w ? "stamp" : "R1 ignored");
        step();
        @(negedge clk);
        chk(!tx_evt && !tx_ovf, "R8/R9 single-cycle pulse", {tx_evt, tx_ovf}, 0);
    endtask

    task automatic tx_read(input logic [1:0] rd);
        tx_rd_hi = rd;
        m_vld = m_vld & ~rd;
        step();
        tx_rd_hi = '0;
        @(negedge clk);
        chk(tx_slot_vld == m_vld, "R7 read clears valid", tx_slot_vld, m_vld);
    endtask

    initial begin
        m_ts[0] = '0; m_ts[1] = '0; m_id[0] = '0; m_id[1] = '0;
        repeat (3) step();
        @(negedge clk);
        chk(rx_out_valid == 0 && rx_out_sof == 0 && rx_out_data == 0 && rx_ts == 0,
            "R10 rx reset state", {rx_out_valid, rx_out_sof, rx_out_data, rx_ts}, 0);
        chk(tx_slot_vld == 0 && tx_slot_ts == 0 && tx_slot_id == 0 && !tx_evt && !tx_ovf,
            "R10 tx reset state", {tx_slot_vld, tx_evt, tx_ovf, tx_slot_id}, 0);
        step();
        rst_n = 1;
        step();
        // R4: pad length sweep across the threshold.
        for (int p = 0; p < 16; p++) rx_frame(3 + p % 5, 1, 1, 1, 5'(p));
        // R1/R2/R3: all enable combinations at the minimum legal pad.
        for (int c = 0; c < 8; c++) rx_frame(2 + c, c[2], c[1], c[0], 5'd8);
        rx_frame(1, 1, 1, 1, 5'd31);
        // Transmit slot sequences (R5..R9, R1).
        tx_frame(1, 1, 0, 1, 16'h0001, 2'b00);
        tx_frame(1, 1, 0, 1, 16'h0002, 2'b00);
        tx_frame(1, 1, 0, 1, 16'h0003, 2'b00);
        tx_frame(1, 1, 0, 1, 16'h0004, 2'b00);
        tx_read(2'b10);
        tx_frame(1, 1, 0, 1, 16'h0005, 2'b00);
        tx_frame(1, 0, 0, 1, 16'h0006, 2'b00);
        tx_frame(1, 0, 1, 1, 16'h0007, 2'b00);
        tx_frame(1, 1, 0, 0, 16'h0008, 2'b00);
        tx_frame(0, 1, 1, 1, 16'h0009, 2'b00);
        tx_read(2'b11);
        for (int i = 0; i < 24; i++) begin
            if (i % 4 == 3) tx_read(2'(i % 3 + 1));
            tx_frame(i % 7 != 6, i % 2 == 0, i % 5 == 0, i % 3 != 1,
                     16'(16'h0100 + i), (i % 6 == 4) ? 2'(1 + i % 2) : 2'b00);
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule